// File: doc/BRIEF.md
# Floating-Point Exception Status Tracker

This block holds the exception and control status word of a floating-point unit. Each time the arithmetic datapath finishes an operation, it pulses a completion strobe and presents five raw exception indications. These are invalid, divide-by-zero, overflow, underflow and inexact. The tracker replaces the per-operation cause field with them and ORs them into a sticky flag field. It compares the new causes with software-programmed enable bits and pulses a trap request when an enabled cause occurred. An operation can be tagged as an approximate reciprocal square root. Such an operation always reports inexact unless it raised some other exception.

Software reads the whole word on `status` and changes it through a write port with a per-bit write mask. Only the architected bits can be written. The block also decodes two control fields for the datapath: a round-toward-zero select and a flush-denormals-to-zero enable. All interfaces are plain level or strobe signals. Nothing is handshaked, and an operation strobe is consumed in the cycle it is presented.

Top module: `fp_status_tracker`

## Requirements
- R1: After reset, `status` is all zero, `trap_req` is low, `rnd_to_zero` is low and `flush_denorm` is low.
- R2: The status word fields are:
  - bits 1:0: rounding mode
  - bits 6:2: sticky flags
  - bits 11:7: trap enables
  - bits 16:12: causes
  - bit 17: flush control
  - bits 19:18: reserved

  Within each five-bit field the bits run from the least significant as inexact, underflow, overflow, divide-by-zero, invalid. The raw flag input `op_flags` uses the same order.
- R3: On a clock edge with `op_done` high (and `wr_en` low), the cause field is cleared and then loaded with the effective flags of that operation. Causes from earlier operations do not survive.
- R4: On the same edge, the effective flags are ORed into the sticky flag field bit for bit. Flag bits are never cleared except by a software write.
- R5: `trap_req` is high for exactly the one cycle after an accepted operation whose effective flags AND the enable field is non-zero. `trap_code` reads 0x120 whenever `trap_req` is high.
- R6: An accepted operation with no effective flag leaves the cause field zero, leaves the sticky flags unchanged and raises no trap.
- R7: When `op_approx` is high and all raw flags are zero, the effective flags are inexact only (5'b00001). When any raw flag is set, the raw flags are used unchanged, whatever `op_approx` is.
- R8: A write (`wr_en` high) sets each status bit whose `wr_mask` bit is one to the matching `wr_data` bit. Other bits are kept. The result is ANDed with the writable mask 0x3FFFF, so bits 19:18 always read zero.
- R9: `rnd_to_zero` is high only when the rounding field holds 2'b01. The encodings 00, 10 and 11 all select round-to-nearest-even, which shows as `rnd_to_zero` low. `flush_denorm` follows status bit 17.
- R10: When `wr_en` and `op_done` are high in the same cycle, only the write takes effect. The operation's flags are discarded and no trap is raised.
- R11: While `op_done` and `wr_en` are both low, `status` holds its value whatever `op_flags` and `op_approx` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done | input | 1 | Operation-complete strobe, one cycle per operation |
| op_flags | input | 5 | Raw exception indications of the completing operation |
| op_approx | input | 1 | Marks the operation as an approximate reciprocal square root |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 20 | Write data |
| wr_mask | input | 20 | Per-bit write mask, 1 = update bit |
| status | output | 20 | Current status word |
| rnd_to_zero | output | 1 | Datapath rounding select: 1 = toward zero, 0 = nearest-even |
| flush_denorm | output | 1 | Datapath denormal flush enable |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_code | output | 12 | Exception code of the trap, 0x120 while trap_req is high |

## Verification
A wrong internal state shows on `status` one cycle after the strobe that caused it. A stale cause bit, a sticky flag that was lost or a corrupted enable field each show up there immediately. A wrong enable or cause also shows, in the same cycle, as a missing or spurious `trap_req`. If the approximate-operation forcing is wrong, a flag-free approximate operation leaves a zero cause field where bit 12 should be set. A wrong write-priority rule lets a same-cycle operation leak its causes into the written word. The bench sweeps every combination of raw flags, enable field and approximate marker, so each such fault appears at the next sampled edge.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int EXC_N     = 5;
  localparam int RM_W      = 2;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = RM_LSB + RM_W;
  localparam int EN_LSB    = FLAG_LSB + EXC_N;
  localparam int CAUSE_LSB = EN_LSB + EXC_N;
  localparam int FLUSH_BIT = CAUSE_LSB + EXC_N;
  localparam int RSVD_W    = 2;
  localparam int REG_W     = FLUSH_BIT + 1 + RSVD_W;
  localparam int CODE_W    = 12;

  localparam logic [REG_W-1:0]  WRITABLE   = {{RSVD_W{1'b0}}, {(FLUSH_BIT+1){1'b1}}};
  localparam logic [RM_W-1:0]   RM_TOWARD0 = 2'b01;
  localparam logic [CODE_W-1:0] FP_TRAP_CODE = 12'h120;

  typedef enum int {
    EXC_INEXACT  = 0,
    EXC_UNDERFLW = 1,
    EXC_OVERFLW  = 2,
    EXC_DIVZERO  = 3,
    EXC_INVALID  = 4
  } exc_bit_e;
endpackage

// File: rtl/fpst_cause_gen.sv
module fpst_cause_gen
  import fpst_pkg::*;
(
  input  logic [EXC_N-1:0] raw,
  input  logic             approx,
  output logic [EXC_N-1:0] eff
);
  logic none_raised;
  assign none_raised = ~|raw;

  for (genvar i = 0; i < EXC_N; i++) begin : g_bit
    if (i == int'(EXC_INEXACT)) begin : g_inx
      assign eff[i] = raw[i] | (approx & none_raised);
    end else begin : g_oth
      assign eff[i] = raw[i];
    end
  end
endmodule

// File: rtl/fpst_next.sv
module fpst_next
  import fpst_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic             op_done,
  input  logic [EXC_N-1:0] eff,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] nxt,
  output logic             trap_nxt
);
  logic [EXC_N-1:0] en_f, flag_f;
  assign en_f   = cur[EN_LSB +: EXC_N];
  assign flag_f = cur[FLAG_LSB +: EXC_N];

  always_comb begin
    nxt      = cur;
    trap_nxt = 1'b0;
    if (wr_en) begin
      nxt = ((cur & ~wr_mask) | (wr_data & wr_mask)) & WRITABLE;
    end else if (op_done) begin
      nxt[CAUSE_LSB +: EXC_N] = eff;
      nxt[FLAG_LSB +: EXC_N]  = flag_f | eff;
      trap_nxt                = |(eff & en_f);
    end
  end
endmodule

// File: rtl/fpst_ctrl_decode.sv
module fpst_ctrl_decode
  import fpst_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  output logic             rnd_to_zero,
  output logic             flush_denorm
);
  assign rnd_to_zero  = (cur[RM_LSB +: RM_W] == RM_TOWARD0);
  assign flush_denorm = cur[FLUSH_BIT];
endmodule

// File: rtl/fp_status_tracker.sv
module fp_status_tracker
  import fpst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic [EXC_N-1:0]  op_flags,
  input  logic              op_approx,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  wr_mask,
  output logic [REG_W-1:0]  status,
  output logic              rnd_to_zero,
  output logic              flush_denorm,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code
);
  logic [REG_W-1:0] stat_q, stat_d;
  logic [EXC_N-1:0] eff;
  logic             trap_q, trap_d;

  fpst_cause_gen u_cause (
    .raw    (op_flags),
    .approx (op_approx),
    .eff    (eff)
  );

  fpst_next u_next (
    .cur      (stat_q),
    .op_done  (op_done),
    .eff      (eff),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .nxt      (stat_d),
    .trap_nxt (trap_d)
  );

  fpst_ctrl_decode u_dec (
    .cur          (stat_q),
    .rnd_to_zero  (rnd_to_zero),
    .flush_denorm (flush_denorm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      trap_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      trap_q <= trap_d;
    end
  end

  assign status    = stat_q;
  assign trap_req  = trap_q;
  assign trap_code = trap_q ? FP_TRAP_CODE : '0;
endmodule

// File: rtl/fpst_checker.sv
module fpst_checker
  import fpst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_done,
  input logic [EXC_N-1:0]  op_flags,
  input logic              op_approx,
  input logic              wr_en,
  input logic [REG_W-1:0]  status,
  input logic              trap_req,
  input logic [CODE_W-1:0] trap_code
);
  assert_sticky_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |->
      ((status[FLAG_LSB +: EXC_N] & $past(status[FLAG_LSB +: EXC_N])) == $past(status[FLAG_LSB +: EXC_N])));

  assert_trap_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ((status[CAUSE_LSB +: EXC_N] & status[EN_LSB +: EXC_N]) != '0) && (trap_code == FP_TRAP_CODE));

  assert_quiet_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_done && !wr_en && (op_flags == '0) && !op_approx) |->
      (status[CAUSE_LSB +: EXC_N] == '0) && !trap_req);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_done && !wr_en));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!op_done && !wr_en) |-> (status == $past(status)));
endmodule

bind fp_status_tracker fpst_checker u_fpst_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_done   (op_done),
  .op_flags  (op_flags),
  .op_approx (op_approx),
  .wr_en     (wr_en),
  .status    (status),
  .trap_req  (trap_req),
  .trap_code (trap_code)
);

// File: tb/sim_fp_status_tracker.sv
module sim_fp_status_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam logic [W-1:0] WMASK = 20'h3FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_done = 1'b0;
  logic [4:0] op_flags = '0;
  logic op_approx = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0, wr_mask = '0;
  logic [W-1:0] status;
  logic rnd_to_zero, flush_denorm, trap_req;
  logic [11:0] trap_code;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] exp_st = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_tracker u0 (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
    .op_approx(op_approx), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .status(status), .rnd_to_zero(rnd_to_zero), .flush_denorm(flush_denorm),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // software write; outputs sampled at the negedge after the capturing edge
  task automatic sw_write(input logic [W-1:0] d, input logic [W-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
    exp_st = ((exp_st & ~m) | (d & m)) & WMASK;
  endtask

  function automatic logic [4:0] eff_of(input logic [4:0] raw, input logic apx);
    return (apx && raw == 5'd0) ? 5'b00001 : raw;
  endfunction

  // operation; returns expected trap
  task automatic do_op(input logic [4:0] raw, input logic apx, output logic etrap);
    logic [4:0] e;
    e = eff_of(raw, apx);
    @(negedge clk);
    op_done = 1'b1; op_flags = raw; op_approx = apx;
    @(negedge clk);
    op_done = 1'b0; op_flags = '0; op_approx = 1'b0;
    etrap = |(e & exp_st[11:7]);
    exp_st[16:12] = e;
    exp_st[6:2] = exp_st[6:2] | e;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic et;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 trap", 32'(trap_req), 32'h0);
    chk("R1 rnd", 32'(rnd_to_zero), 32'h0);
    chk("R1 flush", 32'(flush_denorm), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R7 exhaustive sweep: enables x raw flags x approx
    for (int en = 0; en < 32; en++) begin
      for (int raw = 0; raw < 32; raw++) begin
        for (int apx = 0; apx < 2; apx++) begin
          sw_write(W'(en) << 7, {W{1'b1}});
          do_op(5'(raw), 1'(apx), et);
          chk("R3/R4/R7 status", 32'(status), 32'(exp_st));
          chk("R5 trap", 32'(trap_req), 32'(et));
          chk("R5 code", 32'(trap_code), et ? 32'h120 : 32'h0);
        end
      end
    end
    // R5 one-cycle pulse: trap from a trapping op, then idle
    sw_write(20'h00F80, {W{1'b1}});
    do_op(5'b10000, 1'b0, et);
    chk("R5 trap set", 32'(trap_req), 32'h1);
    @(negedge clk);
    chk("R5 trap drops", 32'(trap_req), 32'h0);

    // R3 R4 sticky accumulation, causes replaced
    sw_write('0, {W{1'b1}});
    do_op(5'b00100, 1'b0, et);
    do_op(5'b01000, 1'b0, et);
    chk("R3 cause replaced", 32'(status[16:12]), 32'h08);
    chk("R4 flags sticky", 32'(status[6:2]), 32'h0C);
    // R6 quiet op
    do_op(5'b00000, 1'b0, et);
    chk("R6 cause zero", 32'(status[16:12]), 32'h0);
    chk("R6 flags kept", 32'(status[6:2]), 32'h0C);
    chk("R6 no trap", 32'(trap_req), 32'h0);

    // R11 idle with raw flags toggling
    @(negedge clk);
    op_flags = 5'b11111; op_approx = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 idle hold", 32'(status), 32'(exp_st));
    op_flags = '0; op_approx = 1'b0;

    // R10 write and op together
    @(negedge clk);
    wr_en = 1'b1; wr_data = 20'h00F80; wr_mask = {W{1'b1}};
    op_done = 1'b1; op_flags = 5'b11111;
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0; op_flags = '0; wr_mask = '0;
    exp_st = 20'h00F80;
    chk("R10 write wins", 32'(status), 32'(exp_st));
    chk("R10 no trap", 32'(trap_req), 32'h0);

    // R8 partial mask and reserved bits
    sw_write(20'hFFFFF, 20'hC0003);
    chk("R8 masked write", 32'(status), 32'(exp_st));
    chk("R8 reserved zero", 32'(status[19:18]), 32'h0);
    sw_write(20'h00000, 20'h00F80);
    chk("R8 mask keeps", 32'(status), 32'h00003);

    // R9 rounding and flush decode
    for (int rm = 0; rm < 4; rm++) begin
      sw_write(W'(rm), 20'h00003);
      chk("R9 rnd", 32'(rnd_to_zero), (rm == 1) ? 32'h1 : 32'h0);
    end
    sw_write(20'h20000, 20'h20000);
    chk("R9 flush on", 32'(flush_denorm), 32'h1);
    sw_write(20'h00000, 20'h20000);
    chk("R9 flush off", 32'(flush_denorm), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule